// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns one asynchronous external interrupt pin into a clean pending request for a priority interrupt controller. The pin is brought into the clock domain through a synchronizer chain. A 16-bit control register then selects how the pin is read: by level or by edge, with rising/high or falling/low polarity. It also holds a mask bit, an edge-trigger enable, a special-nesting flag and a 3-bit priority.

In edge mode a detected edge is held in a one-deep pending latch until the CPU pulses the acknowledge input. In level mode the request follows the pin directly. The masked request, the priority and the nesting flag go to the arbiter. Arbitration, vector generation and the nesting behaviour itself belong to the controller.

Top module: `irq_pin_cond`

## Requirements
- R1: After reset the control register reads 0x000F. The source is masked, the priority is 7, the nesting flag is 0 and the request is low.
- R2: Control register layout: bits [2:0] priority, bit 3 mask, bit 4 level mode, bit 5 polarity, bit 6 special nesting, bit 7 edge-trigger enable. Bits [15:8] ignore writes and read as zero. A write is taken on the rising clock edge where `cfg_we` is 1, and the new value is readable after that edge.
- R3: While the mask bit is 1, `irq_req` stays 0 whatever the pin does.
- R4: With level mode 1 and the source unmasked, `irq_req` is 1 exactly while the synchronized pin is at its active level.
- R5: Polarity 0 makes a high level or a rising edge active. Polarity 1 makes a low level or a falling edge active.
- R6: An edge is latched only while the edge-trigger enable is 1 and level mode is 0. Pin activity at any other time leaves nothing pending.
- R7: A latched edge stays pending, and the request stays high, until acknowledged. Further active edges while it is pending are not counted, so one acknowledge clears everything.
- R8: A one-cycle `irq_ack` clears the edge latch on that clock edge, unless a new active edge is detected in the same cycle. In level mode `irq_ack` has no effect on `irq_req`.
- R9: An edge that arrives while the source is masked is still latched, and raises `irq_req` as soon as the mask is cleared.
- R10: `irq_prio` and `irq_nest` always equal the priority field and the nesting bit of the control register.
- R11: The pin passes through two synchronizer flops. A level request is visible after the second rising clock edge following a pin change, and an edge request after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_async | input | 1 | External interrupt pin, asynchronous |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register read value |
| irq_ack | input | 1 | One-cycle service acknowledge |
| irq_req | output | 1 | Masked request to the arbiter |
| irq_prio | output | 3 | Priority field to the arbiter |
| irq_nest | output | 1 | Special-nesting flag to the arbiter |

## Verification
The pin is driven in every combination of level or edge mode with each polarity. Level runs show that the request follows the pin both up and down. Edge runs show that the request persists after the pin returns, and that an edge of the wrong direction is ignored. Bursts of several edges before one acknowledge tell a one-deep latch apart from a counter. Edges under mask, and pin toggles with the edge enable off or level mode on, separate gating at the output from gating at detection. A cycle-exact probe of the edge path pins down the synchronizer depth.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int PRIO_W   = 3;
   localparam int CFG_W    = 16;
   localparam int B_MASK   = 3;
   localparam int B_LVL    = 4;
   localparam int B_POL    = 5;
   localparam int B_NEST   = 6;
   localparam int B_EDGEEN = 7;
   localparam int USED_W   = B_EDGEEN + 1;

   typedef struct packed {
      logic              edge_en;
      logic              nest;
      logic              pol;
      logic              lvl;
      logic              mask;
      logic [PRIO_W-1:0] prio;
   } cfg_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 2) $error("irqc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_cfg_reg.sv
module irqc_cfg_reg
   import irqc_pkg::*;
#(
   parameter int                REG_W    = CFG_W,
   parameter logic [PRIO_W-1:0] RST_PRIO = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output cfg_t             cfg
);
   localparam int RSV_W = REG_W - USED_W;

   initial begin
      if (REG_W < USED_W) $error("irqc_cfg_reg: REG_W too narrow");
   end

   cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q         <= '0;
         cfg_q.prio    <= RST_PRIO;
         cfg_q.mask    <= 1'b1;
      end else if (we) begin
         cfg_q.prio    <= wdata[PRIO_W-1:0];
         cfg_q.mask    <= wdata[B_MASK];
         cfg_q.lvl     <= wdata[B_LVL];
         cfg_q.pol     <= wdata[B_POL];
         cfg_q.nest    <= wdata[B_NEST];
         cfg_q.edge_en <= wdata[B_EDGEEN];
      end
   end

   generate
      if (RSV_W > 0) begin : g_rsv
         assign rdata = {{RSV_W{1'b0}}, cfg_q};
      end else begin : g_norsv
         assign rdata = cfg_q;
      end
   endgenerate

   assign cfg = cfg_q;

   p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[REG_W-1:USED_W] == '0);
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
   import irqc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  cfg_t cfg,
   input  logic ack,
   output logic req
);
   logic pin_d;
   logic pend_q;
   logic rise, fall, fire, lvl_act, raw_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_d <= 1'b0;
      else        pin_d <= pin_s;
   end

   always_comb begin
      rise    = pin_s & ~pin_d;
      fall    = ~pin_s & pin_d;
      lvl_act = pin_s ^ cfg.pol;
      fire    = cfg.edge_en & ~cfg.lvl & (cfg.pol ? fall : rise);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= fire | (pend_q & ~ack);
   end

   always_comb begin
      raw_req = cfg.lvl ? lvl_act : pend_q;
      req     = raw_req & ~cfg.mask;
   end

   p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !ack |=> pend_q);
   p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !fire |=> !pend_q);
   p_edge_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.edge_en || cfg.lvl) && !pend_q |=> !pend_q);
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond
   import irqc_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                REG_W       = CFG_W,
   parameter logic [PRIO_W-1:0] RST_PRIO    = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_async,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              irq_ack,
   output logic              irq_req,
   output logic [PRIO_W-1:0] irq_prio,
   output logic              irq_nest
);
   initial begin
      if (SYNC_STAGES < 2) $error("irq_pin_cond: SYNC_STAGES must be >= 2");
      if (REG_W < USED_W)  $error("irq_pin_cond: REG_W too narrow");
   end

   cfg_t cfg;
   logic pin_s;

   irqc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_async), .q(pin_s));

   irqc_cfg_reg #(.REG_W(REG_W), .RST_PRIO(RST_PRIO)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .cfg(cfg));

   irqc_detect u_det (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .cfg(cfg),
      .ack(irq_ack), .req(irq_req));

   assign irq_prio = cfg.prio;
   assign irq_nest = cfg.nest;

   p_mask_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[B_MASK] |-> !irq_req);
   p_prio_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_prio == cfg_rdata[PRIO_W-1:0] && irq_nest == cfg_rdata[B_NEST]);
   p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[B_LVL] && !cfg_rdata[B_MASK] |-> irq_req == (pin_s ^ cfg_rdata[B_POL]));
endmodule

// File: tb/sim_irq_pin_cond.sv
module sim_irq_pin_cond;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin = 1'b0;
   logic        we = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        ack = 1'b0;
   logic        req;
   logic [2:0]  prio;
   logic        nest;

   int n_chk = 0;
   int n_fail = 0;
   logic [15:0] cfg_m = 16'h000F;
   bit done = 1'b0;

   typedef struct {
      string       tag;
      logic        e_req;
      logic [15:0] e_rd;
   } item_t;
   item_t q[$];

   always #2 clk = ~clk;

   irq_pin_cond u0 (
      .clk(clk), .rst_n(rst_n), .pin_async(pin), .cfg_we(we),
      .cfg_wdata(wdata), .cfg_rdata(rdata), .irq_ack(ack),
      .irq_req(req), .irq_prio(prio), .irq_nest(nest));

   // monitor: pops expected items and compares outputs
   initial begin
      item_t it;
      forever begin
         wait (q.size() > 0);
         it = q.pop_front();
         n_chk++;
         if (req !== it.e_req) begin
            n_fail++;
            $display("FAIL %s req got %0b exp %0b", it.tag, req, it.e_req);
         end else if (rdata !== it.e_rd) begin
            n_fail++;
            $display("FAIL %s rdata got %h exp %h", it.tag, rdata, it.e_rd);
         end else if (prio !== it.e_rd[2:0] || nest !== it.e_rd[6]) begin
            n_fail++;
            $display("FAIL %s prio/nest got %0d/%0b exp %0d/%0b",
                     it.tag, prio, nest, it.e_rd[2:0], it.e_rd[6]);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_req(input logic e, input string tag);
      item_t it;
      it.tag = tag; it.e_req = e; it.e_rd = cfg_m & 16'h00FF;
      q.push_back(it);
      #0.1;
   endtask

   task automatic wr(input logic [15:0] v);
      we = 1'b1; wdata = v;
      step(1);
      we = 1'b0;
      cfg_m = v;
   endtask

   task automatic set_pin(input logic v);
      pin = v;
      step(3);
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      step(1);
      ack = 1'b0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      expect_req(1'b0, "R1 reset value");

      // R2/R10: reserved bits dropped, fields readable
      wr(16'hAB5A);
      expect_req(1'b0, "R2 reserved write ignored, R10 prio/nest");
      set_pin(1'b1);
      expect_req(1'b0, "R3 masked level high");
      set_pin(1'b0);

      // level mode, active high
      wr(16'h0013);
      set_pin(1'b1);
      expect_req(1'b1, "R4 level high active");
      pulse_ack();
      expect_req(1'b1, "R8 ack ignored in level mode");
      set_pin(1'b0);
      expect_req(1'b0, "R4 level drops with pin");

      // level mode, active low
      wr(16'h0033);
      expect_req(1'b1, "R5 low level active");
      set_pin(1'b1);
      expect_req(1'b0, "R5 high level inactive");
      set_pin(1'b0);

      // edge enable off: no latch
      wr(16'h0004);
      set_pin(1'b1); set_pin(1'b0);
      expect_req(1'b0, "R6 edge enable off");
      // level mode with edge enable: no latch left behind
      wr(16'h0094);
      set_pin(1'b1); set_pin(1'b0);
      wr(16'h0084);
      step(1);
      expect_req(1'b0, "R6 no latch while level mode");

      // rising edge, cycle-exact latency
      wr(16'h0085);
      pin = 1'b1;
      step(2);
      expect_req(1'b0, "R11 not yet after two edges");
      step(1);
      expect_req(1'b1, "R11 edge request on third edge");
      set_pin(1'b0);
      expect_req(1'b1, "R7 held after pin returns");
      set_pin(1'b1); set_pin(1'b0);
      set_pin(1'b1); set_pin(1'b0);
      expect_req(1'b1, "R7 still pending");
      pulse_ack();
      expect_req(1'b0, "R7 one deep, R8 ack clears");

      // falling edge
      wr(16'h00A1);
      set_pin(1'b1);
      expect_req(1'b0, "R5 rising ignored with polarity 1");
      set_pin(1'b0);
      expect_req(1'b1, "R5 falling edge latched");
      pulse_ack();
      expect_req(1'b0, "R8 ack clears falling latch");

      // masked edge
      wr(16'h008D);
      set_pin(1'b1);
      expect_req(1'b0, "R3 masked edge gives no request");
      set_pin(1'b0);
      wr(16'h0085);
      expect_req(1'b1, "R9 masked edge presented after unmask");
      pulse_ack();
      expect_req(1'b0, "R8 cleared after unmask");

      step(2);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
         end
      join_any
      wait (q.size() == 0);
      #1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule